// File: doc/BRIEF.md
# Dual-Bank Byte Parity Generator and Checker

This block guards a memory data word that is split into byte lanes. The default is two lanes: a lower byte and an upper byte. Each lane stores a parity bit of its own. On the write side it computes one even-parity bit per byte, to be stored next to that byte. On the read side it takes each byte together with its stored parity bit and flags a lane whose combined count of ones is odd. Only lanes that take part in the current transfer are checked, so a single-byte access never reports a fault from the idle byte.

The per-lane results are available on their own as active-high debug flags. They are also merged into one active-low error line for the processor. A mode parameter picks the form of that line. In the combinational form it follows the read inputs directly. In the held form it is captured on each clock edge where the read strobe is high, and it keeps that value until the next strobed read. There is no data flow through the block and no handshake: all pins are plain control and status signals. Retrying a failed read is left to software.

Top module: `dp_parity_guard`

## Requirements
- R1: For every lane b (bits b*8+7 down to b*8 of the write word; lane 0 is the low byte), gen_par[b] is set so that the byte plus that bit holds an even number of ones.
- R2: When bank_en[b] is 1 and the read byte of lane b plus rd_par[b] holds an odd number of ones, bank_err[b] is 1. When that count is even, bank_err[b] is 0. Each lane is judged independently of the other lanes.
- R3: When bank_en[b] is 0, bank_err[b] is 0 whatever the read byte and parity bit of that lane hold.
- R4: The merged error is asserted (low) exactly when at least one lane's bank_err is 1. It is released (high) when no lane flags an error.
- R5: In held mode (the default), par_err_n takes the merged error value at each rising clock edge where rd_strobe is 1. At every other edge it keeps its previous value.
- R6: In held mode, par_err_n is 1 while rst_n is low, even if a strobed read with a parity fault is presented during reset.
- R7: In combinational mode, par_err_n follows the merged error of the current read inputs in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the held error output |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 16 | Word being written to memory |
| gen_par | output | 2 | Even-parity bits to store, one per byte lane |
| rd_data | input | 16 | Word read back from memory |
| rd_par | input | 2 | Stored parity bits read back, one per lane |
| bank_en | input | 2 | Lane participates in the current transfer |
| rd_strobe | input | 1 | Qualifies a read for capture of the held error |
| bank_err | output | 2 | Active-high per-lane error flags (debug) |
| par_err_n | output | 1 | Merged active-low parity error for the processor |

## Verification
On every clock edge the assertions check several relations: every generated bit gives an even lane count, an enabled lane with an odd count is flagged, and an idle lane is never flagged. In held mode they also check that the error line keeps its value between strobes and takes the strobed merged value, and that it stays high during reset. The bench scenarios cover the rest. These are the combined outcomes across many data patterns: faults in one lane, in both lanes, and in a lane whose enable is off. They also cover a fault that is presented without a strobe and must leave the held line untouched, and the side-by-side agreement of the held and combinational variants.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  // Form of the merged error line
  typedef enum logic {
    ERR_COMB = 1'b0,
    ERR_HELD = 1'b1
  } err_mode_e;

endpackage

// File: rtl/lane_parity_gen.sv
module lane_parity_gen #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data,
  output logic         par
);
  // even parity: the stored bit cancels an odd count of ones
  assign par = ^data;
endmodule

// File: rtl/lane_checker.sv
module lane_checker #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data,
  input  logic         par,
  input  logic         en,
  output logic         err
);
  logic odd_count;

  assign odd_count = ^{data, par};
  assign err       = en & odd_count;
endmodule

// File: rtl/err_merge.sv
module err_merge
  import dpg_pkg::*;
#(
  parameter int unsigned N    = 2,
  parameter err_mode_e   MODE = ERR_HELD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [N-1:0] lane_err,
  output logic         err_n
);
  logic any_err_n;

  assign any_err_n = ~(|lane_err);

  if (MODE == ERR_HELD) begin : g_held
    logic held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q <= 1'b1;
      else if (strobe) held_q <= any_err_n;
    end
    assign err_n = held_q;
  end else begin : g_comb
    logic unused_ctl;
    assign unused_ctl = clk ^ rst_n ^ strobe;
    assign err_n      = any_err_n;
  end
endmodule

// File: rtl/dp_parity_guard.sv
module dp_parity_guard
  import dpg_pkg::*;
#(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned LANES    = 2,
  parameter err_mode_e   ERR_MODE = ERR_HELD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANE_W*LANES-1:0]  wr_data,
  output logic [LANES-1:0]         gen_par,
  input  logic [LANE_W*LANES-1:0]  rd_data,
  input  logic [LANES-1:0]         rd_par,
  input  logic [LANES-1:0]         bank_en,
  input  logic                     rd_strobe,
  output logic [LANES-1:0]         bank_err,
  output logic                     par_err_n
);
  localparam int unsigned DATA_W = LANE_W * LANES;

  logic [DATA_W-1:0] wr_word;
  logic [DATA_W-1:0] rd_word;

  assign wr_word = wr_data;
  assign rd_word = rd_data;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_parity_gen #(.W(LANE_W)) u_gen (
      .data (wr_word[i*LANE_W +: LANE_W]),
      .par  (gen_par[i])
    );

    lane_checker #(.W(LANE_W)) u_chk (
      .data (rd_word[i*LANE_W +: LANE_W]),
      .par  (rd_par[i]),
      .en   (bank_en[i]),
      .err  (bank_err[i])
    );
  end

  err_merge #(.N(LANES), .MODE(ERR_MODE)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (rd_strobe),
    .lane_err (bank_err),
    .err_n    (par_err_n)
  );
endmodule

// File: rtl/dpg_checker.sv
module dpg_checker
  import dpg_pkg::*;
#(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned LANES    = 2,
  parameter err_mode_e   ERR_MODE = ERR_HELD
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANE_W*LANES-1:0] wr_data,
  input logic [LANES-1:0]        gen_par,
  input logic [LANE_W*LANES-1:0] rd_data,
  input logic [LANES-1:0]        rd_par,
  input logic [LANES-1:0]        bank_en,
  input logic                    rd_strobe,
  input logic [LANES-1:0]        bank_err,
  input logic                    par_err_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // R1
    p_gen_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (^{wr_data[i*LANE_W +: LANE_W], gen_par[i]}) == 1'b0)
      else $error("gen_par lane %0d not even", i);

    // R2
    p_odd_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_en[i] && (^{rd_data[i*LANE_W +: LANE_W], rd_par[i]})) |-> bank_err[i])
      else $error("lane %0d fault missed", i);

    // R3
    p_idle_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en[i] |-> !bank_err[i])
      else $error("idle lane %0d flagged", i);
  end

  if (ERR_MODE == ERR_HELD) begin : g_held
    // R5
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(par_err_n))
      else $error("held error changed without strobe");

    // R4, R5
    p_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> (par_err_n == !$past(|bank_err)))
      else $error("held error not the strobed merge");

    // R6
    always @(negedge clk) begin
      if (!rst_n) begin
        p_reset_high_r6: assert (par_err_n)
          else $error("error line low during reset");
      end
    end
  end else begin : g_comb
    // R7
    p_comb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      par_err_n == !(|bank_err))
      else $error("combinational error line mismatch");
  end
endmodule

bind dp_parity_guard dpg_checker #(
  .LANE_W   (LANE_W),
  .LANES    (LANES),
  .ERR_MODE (ERR_MODE)
) u_chk (.*);

// File: tb/sim_dp_parity_guard.sv
module sim_dp_parity_guard;
  import dpg_pkg::*;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data = '0;
  logic [1:0]  rd_par = '0;
  logic [1:0]  bank_en = '0;
  logic        rd_strobe = 1'b0;

  logic [1:0]  gen_par0, bank_err0, gen_par1, bank_err1;
  logic        par_err_n0, par_err_n1;

  int n_run  = 0;
  int n_fail = 0;
  logic model_held = 1'b1;

  typedef struct {
    logic [1:0] gen;
    logic [1:0] en;
    logic [1:0] berr;
    logic       comb_n;
    logic       held_n;
  } exp_t;

  exp_t sb[$];

  always #(CLK_NS/2) clk = ~clk;

  dp_parity_guard #(.LANE_W(8), .LANES(2), .ERR_MODE(ERR_HELD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .gen_par(gen_par0),
    .rd_data(rd_data), .rd_par(rd_par), .bank_en(bank_en),
    .rd_strobe(rd_strobe), .bank_err(bank_err0), .par_err_n(par_err_n0)
  );

  dp_parity_guard #(.LANE_W(8), .LANES(2), .ERR_MODE(ERR_COMB)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .gen_par(gen_par1),
    .rd_data(rd_data), .rd_par(rd_par), .bank_en(bank_en),
    .rd_strobe(rd_strobe), .bank_err(bank_err1), .par_err_n(par_err_n1)
  );

  function automatic logic ones_odd(input logic [8:0] v);
    int cnt = 0;
    for (int k = 0; k < 9; k++) if (v[k]) cnt++;
    return cnt[0];
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: apply one transfer at the falling edge, push its expectation
  task automatic drive(input logic [15:0] wd, input logic [15:0] rd,
                       input logic [1:0] fault, input logic [1:0] en,
                       input logic strobe);
    exp_t e;
    logic [1:0] p;
    @(negedge clk);
    p[0] = ones_odd({1'b0, rd[7:0]});
    p[1] = ones_odd({1'b0, rd[15:8]});
    wr_data   = wd;
    rd_data   = rd;
    rd_par    = p ^ fault;
    bank_en   = en;
    rd_strobe = strobe;
    e.gen[0]  = ones_odd({1'b0, wd[7:0]});
    e.gen[1]  = ones_odd({1'b0, wd[15:8]});
    e.en      = en;
    e.berr[0] = en[0] & ones_odd({rd[7:0], rd_par[0]});
    e.berr[1] = en[1] & ones_odd({rd[15:8], rd_par[1]});
    e.comb_n  = (e.berr == 2'b00);
    if (strobe) model_held = e.comb_n;
    e.held_n  = model_held;
    sb.push_back(e);
  endtask

  // monitor: results of a transfer are stable just after the next rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check("R1 gen_par", {2'b00, gen_par0}, {2'b00, e.gen});
        for (int b = 0; b < 2; b++) begin
          if (e.en[b]) check("R2 lane flag", {3'b000, bank_err0[b]}, {3'b000, e.berr[b]});
          else         check("R3 idle lane", {3'b000, bank_err0[b]}, 4'h0);
        end
        check("R2 comb variant flags", {2'b00, bank_err1}, {2'b00, e.berr});
        check("R7 R4 comb merge", {3'b000, par_err_n1}, {3'b000, e.comb_n});
        check("R5 held merge", {3'b000, par_err_n0}, {3'b000, e.held_n});
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    s = 32'hACE1_1234;
    repeat (2) @(posedge clk);
    // R6: strobed faulty read during reset leaves the line high
    @(negedge clk);
    rd_data = 16'h0001; rd_par = 2'b00; bank_en = 2'b11; rd_strobe = 1'b1;
    @(negedge clk);
    check("R6 reset value", {3'b000, par_err_n0}, 4'h1);
    rd_strobe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 after release", {3'b000, par_err_n0}, 4'h1);

    // directed patterns
    drive(16'h0000, 16'h0000, 2'b00, 2'b11, 1'b1);
    drive(16'hFFFF, 16'hFFFF, 2'b00, 2'b11, 1'b1);
    drive(16'h0100, 16'h0180, 2'b00, 2'b11, 1'b1);
    drive(16'h1234, 16'h5A3C, 2'b01, 2'b11, 1'b1); // R2 low lane fault
    drive(16'h00FF, 16'h7001, 2'b00, 2'b11, 1'b0); // R5 clean read, no strobe: hold low
    drive(16'h8000, 16'h7001, 2'b00, 2'b11, 1'b1); // R5 release
    drive(16'h0F0F, 16'hC3A5, 2'b10, 2'b11, 1'b0); // R5 fault without strobe: hold high
    drive(16'h0F0F, 16'hC3A5, 2'b10, 2'b11, 1'b1); // R2 high lane fault
    drive(16'hAAAA, 16'h1111, 2'b11, 2'b11, 1'b1); // R2 both lanes
    drive(16'h0001, 16'h2222, 2'b01, 2'b10, 1'b1); // R3 low lane idle
    drive(16'h0101, 16'h3333, 2'b10, 2'b01, 1'b1); // R3 upper idle, byte access
    drive(16'h7F7F, 16'h4444, 2'b11, 2'b00, 1'b1); // R3 no lanes
    drive(16'h0000, 16'h0000, 2'b11, 2'b11, 1'b1); // R4 back to error

    for (int i = 0; i < 48; i++) begin
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      drive(s[15:0], s[31:16], s[3:2] & s[9:8], s[5:4] | {1'b0, s[12]}, s[7]);
    end

    repeat (3) @(posedge clk);
    #2;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule